// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-clock synchronous memory with a late-write pipeline. Address, command and byte-write selects are captured on a rising edge. The data transfer for that command happens on the bus two enabled edges later. Write data is sampled on that edge, and read data is launched on it. Because reads and writes share the same two-cycle distance, the data bus never needs an idle turnaround cycle. A clock enable freezes every register in the block. The output enable acts without a clock. The bidirectional bus is split into `dq_in`, `dq_out` and `dq_oe` for on-chip use.

Command issue is handled by a small burst sequencer. It holds one of three named states:

- **IDLE**: no burst is open.
- **READ**: a read burst is open.
- **WRITE**: a write burst is open.

Its transitions on an enabled edge are:

- **LOAD_SELECT**: load low with all three chip enables active. The sequencer moves to READ or WRITE, as `rw_n` selects.
- **LOAD_DESELECT**: load low with any chip enable inactive. The sequencer moves to IDLE.
- **ADVANCE**: load high. The sequencer keeps its state. In READ or WRITE it issues the next burst address. In IDLE it issues nothing.

A two-stage command pipeline carries each issued operation to the array, which is organised as parallel byte lanes.

Top module: `zbt_sram`

## Requirements
- R1: A read issued on enabled edge k launches the stored word onto `dq_out` at enabled edge k+2. `dq_oe` is high for that cycle when `oe_n` is low.
- R2: A write issued on enabled edge k stores the `dq_in` value sampled at enabled edge k+2.
- R3: Reads and writes may alternate on every cycle. A read of an address written on the previous cycle returns the new data.
- R4: While `cke_n` is high, no command, address, write data or byte select is taken, no memory word changes, and `dq_out` and `dq_oe` hold their values.
- R5: A new operation begins only when `ld_n` is low, `ce1_n` is low, `ce2` is high and `ce3_n` is low. Otherwise the load is a deselect and stores nothing.
- R6: Operations already in the pipeline complete after a deselect.
- R7: `dq_oe` falls two enabled edges after a deselect or a write is issued.
- R8: `oe_n` high forces `dq_oe` low at once, with no clock edge needed.
- R9: `bw_n[i]` low, captured with the address, enables lane i, which is bits 9i+8 down to 9i. Lanes whose select is high keep their old contents.
- R10: With `lin_mode` = 1, advance n (n = 1 to 3) of a burst uses low address bits (start + n) mod 4. The upper address bits stay unchanged.
- R11: With `lin_mode` = 0, advance n uses low address bits start XOR n.
- R12: An advance continues the type of the loaded burst. An advance after a deselect or after reset issues nothing.
- R13: After reset, `dq_oe` is low and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| rw_n | input | 1 | 1 = read, 0 = write |
| ld_n | input | 1 | 0 = load new address, 1 = advance burst |
| cke_n | input | 1 | Active-low clock enable |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| bw_n | input | LANES | Active-low byte-lane write selects |
| lin_mode | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The sensitive coincidence is a clock-enable stall that lands on the cycle where a pending write expects its data, or where a read is being driven. The bench holds `cke_n` high on exactly those cycles while `dq_in` keeps changing. A shadow model then expects the memory to take the word present on the next enabled edge, and expects the driven read word and `dq_oe` to stay frozen. A second coincidence is a deselect issued while a read is still in flight. The model expects exactly one more driven cycle, followed by release of the bus.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    // Operation carried by the sequencer state and by each pipeline stage
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_t;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              ld,
    input  logic              sel,
    input  logic              rd,
    input  logic              lin,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LANES-1:0]  be_in,
    output op_t               op_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LANES-1:0]  be_out
);
    localparam int CNT_W = 2;

    op_t               state;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  ofs;

    // Output process: the operation issued in this cycle
    always_comb begin
        cnt_nx   = cnt + 1'b1;
        ofs      = lin ? (base[CNT_W-1:0] + cnt_nx) : (base[CNT_W-1:0] ^ cnt_nx);
        op_out   = OP_IDLE;
        addr_out = addr_in;
        be_out   = be_in;
        if (ld) begin
            if (sel) op_out = rd ? OP_READ : OP_WRITE;
        end else begin
            unique case (state)
                OP_IDLE: op_out = OP_IDLE;
                OP_READ, OP_WRITE: begin
                    op_out   = state;
                    addr_out = {base[ADDR_W-1:CNT_W], ofs};
                end
                default: op_out = OP_IDLE;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OP_IDLE;
            base  <= '0;
            cnt   <= '0;
        end else if (cke) begin
            state <= op_out;
            if (ld) begin
                base <= addr_in;
                cnt  <= '0;
            end else begin
                cnt  <= cnt_nx;
            end
        end
    end

    // R5
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && ld && !sel) |=> (state == OP_IDLE));

    // R12
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !ld && state == OP_IDLE) |=> (state == OP_IDLE));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && be[l]) store[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= store[addr];
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rw_n,
    input  logic                    ld_n,
    input  logic                    cke_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    lin_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    localparam int DW = LANES * LANE_W;

    logic              cke;
    logic              sel_all;
    op_t               iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  iss_be;

    op_t               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_be, s2_be;
    logic              drv_q;
    logic [DW-1:0]     rd_word;

    assign cke     = !cke_n;
    assign sel_all = !ce1_n && ce2 && !ce3_n;

    zbt_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .ld       (!ld_n),
        .sel      (sel_all),
        .rd       (rw_n),
        .lin      (lin_mode),
        .addr_in  (addr),
        .be_in    (~bw_n),
        .op_out   (iss_op),
        .addr_out (iss_addr),
        .be_out   (iss_be)
    );

    // Two-stage command pipeline; stage 2 is the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_IDLE;
            s2_op   <= OP_IDLE;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_be   <= '0;
            s2_be   <= '0;
            drv_q   <= 1'b0;
        end else if (cke) begin
            s1_op   <= iss_op;
            s1_addr <= iss_addr;
            s1_be   <= iss_be;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
            drv_q   <= (s2_op == OP_READ);
        end
    end

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cke && s2_op == OP_WRITE),
        .rd_en (cke && s2_op == OP_READ),
        .addr  (s2_addr),
        .be    (s2_be),
        .wdata (dq_in),
        .rdata (rd_word)
    );

    assign dq_out = rd_word;
    assign dq_oe  = drv_q && !oe_n;

    // R1
    stage_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op != OP_IDLE) |=> (s2_op == $past(s1_op)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dq_out) && $stable(drv_q) && $stable(s2_op)));

    // R6
    drain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_op == OP_READ) |=> drv_q);

    // R7
    wr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_op == OP_WRITE) |=> !drv_q);
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        rw_n = 1'b1;
    logic        ld_n = 1'b0;
    logic        cke_n = 1'b0;
    logic        ce1_n = 1'b1;
    logic        ce2 = 1'b1;
    logic        ce3_n = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic        lin_mode = 1'b1;
    logic        oe_n = 1'b0;
    logic [35:0] dq_in = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R13";

    // shadow model
    logic [35:0] sh [64];
    int          m1_k = 0, m2_k = 0, bk = 0;
    logic [5:0]  m1_a = '0, m2_a = '0, bbase = '0;
    logic [3:0]  m1_bw = 4'hF, m2_bw = 4'hF;
    logic [1:0]  bn = '0;
    logic        drv_m = 1'b0;
    logic [35:0] dout_m = '0;

    zbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rw_n(rw_n), .ld_n(ld_n),
        .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .bw_n(bw_n),
        .lin_mode(lin_mode), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    task automatic chk(input logic ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [35:0] pat(input int c);
        logic [8:0] v = c[8:0];
        return {v + 9'd3, v ^ 9'h0AA, ~v, v};
    endfunction

    // one clock: apply stimulus, advance the model, check outputs
    task automatic tick();
        int          nk;
        logic [5:0]  na;
        logic [35:0] d;
        d = pat(cyc);
        dq_in = d;
        @(posedge clk);
        if (!cke_n) begin
            if (m2_k == 2)
                for (int l = 0; l < 4; l++)
                    if (!m2_bw[l]) sh[m2_a][l*9 +: 9] = d[l*9 +: 9];
            drv_m = (m2_k == 1);
            if (m2_k == 1) dout_m = sh[m2_a];
            nk = 0;
            na = addr;
            if (!ld_n) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    nk = rw_n ? 1 : 2;
                    bbase = addr;
                    bn = 2'd0;
                end
                bk = nk;
            end else if (bk != 0) begin
                bn = bn + 2'd1;
                nk = bk;
                na = {bbase[5:2], lin_mode ? bbase[1:0] + bn : bbase[1:0] ^ bn};
            end
            m2_k = m1_k; m2_a = m1_a; m2_bw = m1_bw;
            m1_k = nk;   m1_a = na;   m1_bw = bw_n;
        end
        cyc++;
        #2;
        chk(dq_oe == (drv_m && !oe_n), cur_req, {35'd0, dq_oe}, {35'd0, drv_m && !oe_n});
        if (drv_m) chk(dq_out == dout_m, cur_req, dq_out, dout_m);
    endtask

    task automatic sel_on();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; cke_n = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] b);
        sel_on(); ld_n = 1'b0; rw_n = 1'b0; addr = a; bw_n = b; tick();
    endtask

    task automatic rd(input logic [5:0] a);
        sel_on(); ld_n = 1'b0; rw_n = 1'b1; addr = a; bw_n = 4'hF; tick();
    endtask

    // deselect load attempting a write; which picks the inactive enable
    task automatic des(input int which);
        ld_n = 1'b0; rw_n = 1'b0; bw_n = 4'h0; cke_n = 1'b0;
        ce1_n = (which == 0); ce2 = (which != 1); ce3_n = (which == 2);
        tick();
    endtask

    task automatic adv(input logic lin, input logic [3:0] b);
        ld_n = 1'b1; cke_n = 1'b0; lin_mode = lin; bw_n = b; addr = 6'h3F; tick();
    endtask

    task automatic stall();
        cke_n = 1'b1; ld_n = 1'b0; rw_n = 1'b0; bw_n = 4'h0; sel_on(); cke_n = 1'b1; tick();
        cke_n = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        // R13 reset state
        chk(dq_oe == 1'b0, "R13", {35'd0, dq_oe}, 36'd0);
        rst_n = 1'b1;
        cur_req = "R13"; des(0); des(0);

        // R2 fill every word, R1 read every word back
        cur_req = "R2";
        for (int a = 0; a < 64; a++) wr(a[5:0], 4'h0);
        cur_req = "R1";
        for (int a = 0; a < 64; a++) rd(a[5:0]);
        des(1); des(1);

        // R3 alternate write/read with no gaps, read-after-write same address
        cur_req = "R3";
        for (int a = 0; a < 64; a++) begin
            wr(a[5:0], 4'h0);
            rd(a[5:0]);
        end
        for (int a = 0; a < 32; a++) begin
            rd(a[5:0] + 6'd1);
            wr(a[5:0], 4'h0);
        end
        des(2); des(2);

        // R9 every byte-lane combination
        cur_req = "R9";
        for (int m = 0; m < 16; m++) begin
            wr(6'd7, m[3:0]);
            rd(6'd7);
        end
        des(0); des(0);

        // R4 stalls over a pending write data phase and over a driven read
        cur_req = "R4";
        wr(6'd9, 4'h0); stall(); stall(); des(0); stall(); des(0);
        rd(6'd9); des(0); des(0); stall(); stall();
        rd(6'd9); stall(); des(1); stall(); des(1); des(1);

        // R5 deselected loads must not write
        cur_req = "R5";
        for (int w = 0; w < 3; w++) begin
            des(w); des(w); des(w);
            rd(6'd12); des(w); des(w);
        end

        // R6 and R7: drain after deselect, float after write
        cur_req = "R6";
        rd(6'd3); des(2); des(2); des(2);
        cur_req = "R7";
        rd(6'd4); wr(6'd5, 4'h0); des(0); des(0); des(0);

        // R8 asynchronous output enable
        cur_req = "R8";
        rd(6'd6); des(0); des(0);
        #1 oe_n = 1'b1; #1;
        chk(dq_oe == 1'b0, "R8", {35'd0, dq_oe}, 36'd0);
        oe_n = 1'b0; #1;
        chk(dq_oe == 1'b1, "R8", {35'd0, dq_oe}, 36'd1);
        des(0);

        // R10 linear and R11 interleaved bursts, all starts
        for (int lm = 1; lm >= 0; lm--) begin
            cur_req = (lm == 1) ? "R10" : "R11";
            for (int s = 0; s < 4; s++) begin
                wr(6'd16 + s[5:0], 4'h0);
                adv(lm[0], 4'h0); adv(lm[0], 4'h5); adv(lm[0], 4'h0);
                des(0); des(0);
                for (int a = 16; a < 20; a++) rd(a[5:0]);
                rd(6'd40 + s[5:0]);
                adv(lm[0], 4'hF); adv(lm[0], 4'hF); adv(lm[0], 4'hF);
                des(0); des(0);
            end
        end

        // R12 advance after deselect issues nothing
        cur_req = "R12";
        des(1); adv(1'b1, 4'h0); adv(1'b1, 4'h0); adv(1'b0, 4'h0); adv(1'b1, 4'h0);
        for (int a = 0; a < 8; a++) rd(a[5:0]);
        des(0); des(0);

        summary();
    end
endmodule